// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This block keeps a small set of hardware lock flags shared by two independent ports, called left and right, that sit on either side of a shared memory. A port claims a flag by writing a zero to it. It then reads the flag back: a zero means the port now owns the flag, and a one means it does not. An owner gives the flag back by writing a one. Only data bit 0 carries the written value. On a read, the flag value is driven on every line of the port's data bus.

Each read returns a value latched at the start of the read. The value stays fixed for as long as the read strobe is held on the same flag address, whatever the other port does meanwhile. A request for a flag the other side holds is remembered as pending. That request is granted on the same clock edge at which the owner releases the flag. When both ports claim the same free flag on the same edge, the left port wins. The right port's request then waits as pending.

The design is fully synchronous. Every strobe is sampled on the rising clock edge, and the read result appears one edge after the read strobe.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset every flag is free and nothing is pending. Every flag then reads as all ones on both ports. A reset applied later restores this state.
- R2: A zero write (select=1, write=1, data bit 0 = 0) to a free flag gives it to the writer at that edge. From then on the owner reads all zeros and the other port reads all ones.
- R3: While a read is held, every one of the DATA_W data lines carries the flag value. The bus is therefore either all zeros or all ones.
- R4: A read needs select=1, write=0 and output enable=1. In any other cycle the read bus is all zeros one edge later. A write with select=0 has no effect on the flags.
- R5: Only data bit 0 of a write is used. 16'hFFFE is a request and 16'h0001 is a release.
- R6: The read value is captured on the first edge of a read, or on an edge where the flag address changes. It is held while the read stays on that address, even if the other port's write changes the flag at the same time.
- R7: When both ports request the same free flag on the same edge, the left port gets it. The right port sees it as taken.
- R8: A request for a flag owned by the other port is stored as pending. It is granted on the edge at which the owner releases the flag.
- R9: A release written by a port that does not own the flag only clears that port's own pending request. The flag stays with its owner, and after the owner's release it is free rather than granted.
- R10: The flag address (ADDR_W bits, values 0..NUM_FLAGS-1) selects one flag. Flags do not affect each other.
- R11: No flag is ever owned by both ports at once, and a port never holds a pending request for a flag it already owns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sem_en | input | 1 | Left port flag select |
| l_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable for reads |
| l_addr | input | ADDR_W | Left port flag address |
| l_wdata | input | DATA_W | Left port write data, bit 0 used |
| l_rdata | output | DATA_W | Left port read data, flag value replicated |
| r_sem_en | input | 1 | Right port flag select |
| r_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable for reads |
| r_addr | input | ADDR_W | Right port flag address |
| r_wdata | input | DATA_W | Right port write data, bit 0 used |
| r_rdata | output | DATA_W | Right port read data, flag value replicated |

## Verification
The claim-and-read-back sequence is driven in several patterns:
- One port alone claims a flag. This separates the owner's view from the other port's view.
- One port claims a flag the other already owns, then the owner releases it. This tells a stored pending request apart from a lost one.
- Both ports claim the same flag on the same edge. This shows that exactly one port, the left, wins.
- The non-owner writes a release. This separates clearing a pending request from freeing the flag.

Separate patterns cover the remaining rules:
- Reads with output enable low, and writes with select low, show that the strobe qualification keeps those cycles from reaching the flags.
- Write data with bit 0 opposite to all other bits shows that only bit 0 counts.
- A read held across the owner's release, followed by a fresh read, separates the latched value from the live flag state.

// File: rtl/sem_flag_pkg.sv
// Package: shared types for the semaphore flag unit.
// Assumes: both ports use the same flag count and data width.
package sem_flag_pkg;

    // Per-flag state held in each flag cell
    typedef struct packed {
        logic own_l;   // left port owns the flag
        logic own_r;   // right port owns the flag
        logic pend_l;  // left request waiting for release
        logic pend_r;  // right request waiting for release
    } sem_cell_t;

    localparam sem_cell_t SEM_CELL_IDLE = '{own_l: 1'b0, own_r: 1'b0,
                                            pend_l: 1'b0, pend_r: 1'b0};

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's strobes into per-flag request and release pulses,
// and a read-active qualifier.
// Assumes: strobes are sampled on the rising clock edge by the consumers;
// only the write value bit (data bit 0) is passed in.
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sem_en,
    input  logic                 wr,
    input  logic                 oe,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic                 rd_act
);

    logic wr_act;

    // Qualify write and read cycles from the select and direction strobes
    always_comb begin
        wr_act = sem_en && wr;
        rd_act = sem_en && !wr && oe;
    end

    // One decoder slice per flag: request on 0, release on 1
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        always_comb begin
            req_vec[i] = wr_act && !wbit && (addr == ADDR_W'(i));
            rel_vec[i] = wr_act &&  wbit && (addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/sem_flag_cell.sv
// Module: sem_flag_cell
// Holds ownership and pending state of one flag.
// Releases apply first, then new requests, then a free flag is handed
// to a pending requester, the left port first.
// Assumes: per port, request and release are never both high.
module sem_flag_cell
    import sem_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_l,
    input  logic      rel_l,
    input  logic      req_r,
    input  logic      rel_r,
    output sem_cell_t state
);

    sem_cell_t nxt;

    // Next-state: release, record request, grant free flag
    always_comb begin
        nxt = state;
        if (rel_l) begin
            nxt.own_l  = 1'b0;
            nxt.pend_l = 1'b0;
        end
        if (rel_r) begin
            nxt.own_r  = 1'b0;
            nxt.pend_r = 1'b0;
        end
        if (req_l && !nxt.own_l) nxt.pend_l = 1'b1;
        if (req_r && !nxt.own_r) nxt.pend_r = 1'b1;
        if (!nxt.own_l && !nxt.own_r) begin
            if (nxt.pend_l) begin
                nxt.own_l  = 1'b1;
                nxt.pend_l = 1'b0;
            end else if (nxt.pend_r) begin
                nxt.own_r  = 1'b1;
                nxt.pend_r = 1'b0;
            end
        end
    end

    // State register with synchronous reset to free
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEM_CELL_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/sem_read_latch.sv
// Module: sem_read_latch
// Captures one port's view of the addressed flag when a read starts
// (or its address changes) and holds it while the read lasts.
// Drives the value on every data line, zeros when not reading.
// Assumes: view bit is 0 where this port owns the flag, else 1.
module sem_read_latch #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = $clog2(NUM_FLAGS),
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_act,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] view,
    output logic [DATA_W-1:0]    rdata
);

    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              bit_q;
    logic              start;

    // A new read begins on its first cycle or on an address change
    always_comb begin
        start = rd_act && (!rd_q || (addr != addr_q));
    end

    // Read tracking and value capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
            bit_q  <= 1'b1;
        end else begin
            rd_q <= rd_act;
            if (start) begin
                addr_q <= addr;
                bit_q  <= view[addr];
            end
        end
    end

    // Replicate the held value onto the whole bus during a read
    always_comb begin
        rdata = rd_q ? {DATA_W{bit_q}} : '0;
    end

endmodule

// File: rtl/sem_flag_unit.sv
// Module: sem_flag_unit (top)
// Shared lock flags between a left and a right port. Each port claims a
// flag with a zero write, reads it back (0 = owned by this port), and
// releases with a one write. Conflicting requests wait as pending;
// same-edge ties go to the left port.
// Assumes: NUM_FLAGS is a power of two; all strobes synchronous to clk.
module sem_flag_unit
    import sem_flag_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 16,
    localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sem_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    logic                 l_rd, r_rd;
    logic [NUM_FLAGS-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;
    logic [NUM_FLAGS-1:0] l_view, r_view;
    logic                 unused_wdata_hi;

    // Upper write data bits carry no meaning for a flag write
    always_comb begin
        unused_wdata_hi = ^{l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};
    end

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_l (
        .sem_en (l_sem_en),
        .wr     (l_wr),
        .oe     (l_oe),
        .addr   (l_addr),
        .wbit   (l_wdata[0]),
        .req_vec(l_req),
        .rel_vec(l_rel),
        .rd_act (l_rd)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_dec_r (
        .sem_en (r_sem_en),
        .wr     (r_wr),
        .oe     (r_oe),
        .addr   (r_addr),
        .wbit   (r_wdata[0]),
        .req_vec(r_req),
        .rel_vec(r_rel),
        .rd_act (r_rd)
    );

    // One cell per flag
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sem_cell_t st;

        sem_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .req_l(l_req[i]),
            .rel_l(l_rel[i]),
            .req_r(r_req[i]),
            .rel_r(r_rel[i]),
            .state(st)
        );

        // Flatten cell state into per-port vectors and views
        always_comb begin
            own_l_vec[i]  = st.own_l;
            own_r_vec[i]  = st.own_r;
            pend_l_vec[i] = st.pend_l;
            pend_r_vec[i] = st.pend_r;
            l_view[i]     = !st.own_l;
            r_view[i]     = !st.own_r;
        end
    end

    sem_read_latch #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_act(l_rd),
        .addr  (l_addr),
        .view  (l_view),
        .rdata (l_rdata)
    );

    sem_read_latch #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_act(r_rd),
        .addr  (r_addr),
        .view  (r_view),
        .rdata (r_rdata)
    );

endmodule

// File: rtl/sem_flag_unit_chk.sv
// Module: sem_flag_unit_chk
// Property checker bound to sem_flag_unit. Observes ports and the
// flattened flag state; drives nothing.
module sem_flag_unit_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sem_en,
    input logic                 l_wr,
    input logic                 l_oe,
    input logic [ADDR_W-1:0]    l_addr,
    input logic                 l_wbit,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 r_sem_en,
    input logic                 r_wr,
    input logic                 r_oe,
    input logic [ADDR_W-1:0]    r_addr,
    input logic                 r_wbit,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r,
    input logic [NUM_FLAGS-1:0] pend_l,
    input logic [NUM_FLAGS-1:0] pend_r
);

    logic [1:0] cyc;
    logic       l_rd_c, r_rd_c, l_w0, r_w0, l_w1, r_wr_c;

    // Cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // Port-level cycle classes
    always_comb begin
        l_rd_c = l_sem_en && !l_wr && l_oe;
        r_rd_c = r_sem_en && !r_wr && r_oe;
        l_w0   = l_sem_en && l_wr && !l_wbit;
        r_w0   = r_sem_en && r_wr && !r_wbit;
        l_w1   = l_sem_en && l_wr && l_wbit;
        r_wr_c = r_sem_en && r_wr;
    end

    assert_reset_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (own_l == '0 && own_r == '0 && pend_l == '0 &&
                           pend_r == '0 && l_rdata == '0 && r_rdata == '0));

    assert_bus_replicated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    assert_idle_bus_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) && !$past(l_rd_c) && !$past(r_rd_c) |-> (l_rdata == '0 && r_rdata == '0));

    assert_read_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) && $past(l_rd_c) && $past(l_rd_c, 2) &&
        ($past(l_addr) == $past(l_addr, 2)) |-> $stable(l_rdata));

    assert_tie_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
        l_w0 && r_w0 && (l_addr == r_addr) && !own_l[l_addr] && !own_r[l_addr]
        |=> own_l[$past(l_addr)] && !own_r[$past(l_addr)] && pend_r[$past(l_addr)]);

    assert_pending_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        l_w1 && own_l[l_addr] && pend_r[l_addr] && !(r_wr_c && r_addr == l_addr)
        |=> own_r[$past(l_addr)]);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_l & own_r) == '0) && ((own_l & pend_l) == '0) && ((own_r & pend_r) == '0));

endmodule

bind sem_flag_unit sem_flag_unit_chk #(
    .NUM_FLAGS(NUM_FLAGS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sem_en(l_sem_en),
    .l_wr    (l_wr),
    .l_oe    (l_oe),
    .l_addr  (l_addr),
    .l_wbit  (l_wdata[0]),
    .l_rdata (l_rdata),
    .r_sem_en(r_sem_en),
    .r_wr    (r_wr),
    .r_oe    (r_oe),
    .r_addr  (r_addr),
    .r_wbit  (r_wdata[0]),
    .r_rdata (r_rdata),
    .own_l   (own_l_vec),
    .own_r   (own_r_vec),
    .pend_l  (pend_l_vec),
    .pend_r  (pend_r_vec)
);

// File: tb/sem_flag_unit_tb_top.sv
// Bench for sem_flag_unit: a vector table, then directed tests.
module sem_flag_unit_tb_top;

    localparam int NF = 8;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam logic [DW-1:0] ONES  = '1;
    localparam logic [DW-1:0] ZEROS = '0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          l_sem_en, l_wr, l_oe, r_sem_en, r_wr, r_oe;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sem_flag_unit #(.NUM_FLAGS(NF), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sem_en(l_sem_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_en(r_sem_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // op: 0 idle, 1 write (bit), 2 read
    // entry: lop[17:16] laddr[15:13] lbit[12] rop[11:10] raddr[9:7] rbit[6]
    //        exp_l[5] exp_r[4] req[3:0]
    localparam int NV = 18;
    localparam logic [17:0] VEC [NV] = '{
        {2'd1,3'd0,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd2},  // L claims f0
        {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b0,1'b1, 4'd2},  // R2 owner 0, other 1
        {2'd0,3'd0,1'b0, 2'd1,3'd0,1'b0, 1'b0,1'b0, 4'd8},  // R claims owned f0
        {2'd2,3'd1,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b1, 4'd8},  // R8 still not R's; R10 f1 free
        {2'd1,3'd0,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd8},  // L releases f0
        {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b0, 4'd8},  // R8 granted to R
        {2'd0,3'd0,1'b0, 2'd1,3'd0,1'b1, 1'b0,1'b0, 4'd8},  // R releases f0
        {2'd1,3'd3,1'b0, 2'd1,3'd3,1'b0, 1'b0,1'b0, 4'd7},  // tie on f3
        {2'd2,3'd3,1'b0, 2'd2,3'd3,1'b0, 1'b0,1'b1, 4'd7},  // R7 left wins, R11 one owner
        {2'd0,3'd0,1'b0, 2'd1,3'd3,1'b1, 1'b0,1'b0, 4'd9},  // R non-owner release
        {2'd2,3'd3,1'b0, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd9},  // R9 owner unaffected
        {2'd1,3'd3,1'b1, 2'd0,3'd0,1'b0, 1'b0,1'b0, 4'd9},  // L releases f3
        {2'd2,3'd3,1'b0, 2'd2,3'd3,1'b0, 1'b1,1'b1, 4'd9},  // R9 not granted: free
        {2'd0,3'd0,1'b0, 2'd1,3'd7,1'b0, 1'b0,1'b0, 4'd10}, // R claims f7
        {2'd2,3'd7,1'b0, 2'd2,3'd7,1'b0, 1'b1,1'b0, 4'd10}, // R10 f7
        {2'd2,3'd0,1'b0, 2'd2,3'd0,1'b0, 1'b1,1'b1, 4'd10}, // R10 f0 unaffected by f7
        {2'd0,3'd0,1'b0, 2'd1,3'd7,1'b1, 1'b0,1'b0, 4'd2},  // R releases f7
        {2'd2,3'd7,1'b0, 2'd2,3'd7,1'b0, 1'b1,1'b1, 4'd2}   // R2 free again
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_l(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_sem_en = (op != 0);
        l_wr     = (op == 1);
        l_oe     = (op == 2);
        l_addr   = a;
        l_wdata  = d;
    endtask

    task automatic drive_r(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_sem_en = (op != 0);
        r_wr     = (op == 1);
        r_oe     = (op == 2);
        r_addr   = a;
        r_wdata  = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive_l(0, '0, '0);
        drive_r(0, '0, '0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic check_all_free(input string tag);
        for (int f = 0; f < NF; f++) begin
            drive_l(2, AW'(f), '0);
            drive_r(2, AW'(f), '0);
            tick();
            check({tag, " left"},  l_rdata, ONES);
            check({tag, " right"}, r_rdata, ONES);
        end
        drive_l(0, '0, '0);
        drive_r(0, '0, '0);
        tick();
    endtask

    function automatic logic [DW-1:0] wval(input logic b);
        return b ? 16'h0001 : 16'hFFFE;
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1: reset state, all flags free
        check("R1 idle bus after reset left", l_rdata, ZEROS);
        check_all_free("R1 reset");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [17:0] e;
            e = VEC[v];
            drive_l(int'(e[17:16]), e[15:13], wval(e[12]));
            drive_r(int'(e[11:10]), e[9:7],   wval(e[6]));
            tick();
            if (e[17:16] == 2'd2)
                check($sformatf("R%0d vec %0d left (R3 full bus)", e[3:0], v),
                      l_rdata, e[5] ? ONES : ZEROS);
            if (e[11:10] == 2'd2)
                check($sformatf("R%0d vec %0d right (R3 full bus)", e[3:0], v),
                      r_rdata, e[4] ? ONES : ZEROS);
        end
        drive_l(0, '0, '0);
        drive_r(0, '0, '0);
        tick();
        check("R4 bus zero when no read", l_rdata, ZEROS);

        // R4: write without select is ignored; read with oe low gives zeros
        drive_l(1, 3'd2, 16'h0000);
        l_sem_en = 1'b0;
        tick();
        drive_l(2, 3'd2, '0);
        l_oe = 1'b0;
        tick();
        check("R4 oe low read left", l_rdata, ZEROS);
        drive_l(2, 3'd2, '0);
        tick();
        check("R4 unselected write ignored f2", l_rdata, ONES);

        // R5: only bit 0 counts
        drive_l(1, 3'd4, 16'hFFFE);
        tick();
        drive_l(2, 3'd4, '0);
        drive_r(2, 3'd4, '0);
        tick();
        check("R5 FFFE is a request left", l_rdata, ZEROS);
        check("R5 FFFE is a request right", r_rdata, ONES);
        drive_l(1, 3'd4, 16'h0001);
        drive_r(0, '0, '0);
        tick();
        drive_l(2, 3'd4, '0);
        tick();
        check("R5 0001 is a release", l_rdata, ONES);

        // R6: held read not changed by the other port's release
        drive_l(1, 3'd6, wval(1'b0));
        tick();
        drive_l(0, '0, '0);
        drive_r(1, 3'd6, wval(1'b0));
        tick();
        drive_r(2, 3'd6, '0);
        tick();
        check("R6 read start right", r_rdata, ONES);
        drive_l(1, 3'd6, wval(1'b1));
        tick();
        check("R6 held across release", r_rdata, ONES);
        drive_l(0, '0, '0);
        tick();
        check("R6 still held", r_rdata, ONES);
        drive_r(0, '0, '0);
        tick();
        drive_r(2, 3'd6, '0);
        tick();
        check("R6 new read shows R8 grant", r_rdata, ZEROS);
        drive_r(0, '0, '0);
        tick();

        // R1: reset while flags are held clears them
        do_reset();
        check_all_free("R1 re-reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule